// File: doc/BRIEF.md
# Bus Clock Rate-Change Sequencer

This block applies a new bus-domain clock rate as one coordinated update of a PLL and a bank of sixteen integer dividers. A requester presents a rate in MHz together with the PLL rate now running. The block checks the rate against a small list of supported values. From the match it takes a target PLL rate and one divisor for each divider. It then carries out two steps in an order that keeps every derived clock at or below its final frequency during the change.

The PLL change is handed to an external PLL controller over a request/acknowledge pair, which returns a result code. Divider settings go out one word at a time on a valid/ready register-write port, at fixed ascending addresses. When the last step has finished, a one-cycle done strobe reports the result. If the rate was not in the list, the done strobe carries a rejection flag, and no write or PLL request has been made.

The controller has five states. ST_IDLE waits for a request. ST_PLL_PRE reprograms the PLL before the dividers. ST_DIV_WR streams the divider words. ST_PLL_POST reprograms the PLL after the dividers. ST_FINISH pulses done.

The transitions are:
- ST_IDLE→ST_FINISH for an unsupported rate.
- ST_IDLE→ST_PLL_PRE when the new PLL rate is below the current one.
- ST_IDLE→ST_DIV_WR otherwise.
- ST_PLL_PRE→ST_DIV_WR on acknowledge.
- ST_DIV_WR→ST_FINISH after the last write if the PLL went first, else ST_DIV_WR→ST_PLL_POST.
- ST_PLL_POST→ST_FINISH on acknowledge.
- ST_FINISH→ST_IDLE always.

Top module: `bus_rate_seq`

## Requirements
- R1: The supported rates are 200, 400, 600 and 800 MHz, which are indices 0 to 3. Any other rate gives done with rejected=1 in the cycle after acceptance, with no register write and no PLL request.
- R2: The PLL target presented with pll_req is 800, 800, 600 and 800 MHz for indices 0 to 3.
- R3: When the target PLL rate is strictly below cur_pll_mhz (sampled at acceptance), the PLL step completes before the first divider write.
- R4: When the target PLL rate is greater than or equal to cur_pll_mhz, all sixteen divider writes complete before pll_req is raised. The equal case still issues a PLL request.
- R5: Exactly sixteen writes are made, one per valid/ready handshake. The address of write k (k = 0 to 15) is 0x180 + 0x10*k, and the writes go in ascending order.
- R6: Divisor values by write number k:
  - k=1 gets 4, 2, 1, 1 for indices 0 to 3.
  - k=0, 8, 10 and 13 have a base of 4.
  - k=11 has a base of 8.
  - k=12 and 14 have a base of 24.
  - k=15 has a base of 16.
  - k=6 is 1.
  - k=2 to 5, 7 and 9 are 2.
  - A base of 3 or more becomes base*3/4 at index 2. Every other value equals its base.
- R7: While wr_valid is high and wr_ready is low, wr_valid, wr_addr and wr_data hold their values.
- R8: pll_req stays high, with a stable target, until pll_ack. The result output at done equals the pll_result sampled with the acknowledge.
- R9: done is a one-cycle pulse. req_ready is high only in ST_IDLE. A request raised while the block is busy is ignored.
- R10: After reset the block is idle: req_ready=1 and done, wr_valid and pll_req are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Rate-change request |
| req_ready | output | 1 | Block idle and accepting a request |
| req_rate_mhz | input | 12 | Requested bus rate in MHz |
| cur_pll_mhz | input | 12 | Current PLL rate in MHz, sampled at acceptance |
| pll_req | output | 1 | PLL reprogramming request |
| pll_target_mhz | output | 12 | PLL rate requested |
| pll_ack | input | 1 | PLL step finished |
| pll_result | input | 2 | Result code of the PLL step, valid with pll_ack |
| wr_valid | output | 1 | Divider write valid |
| wr_ready | input | 1 | Divider write accepted |
| wr_addr | output | 12 | Divider register address |
| wr_data | output | 8 | Divisor value |
| done | output | 1 | Sequence finished, one cycle |
| rejected | output | 1 | With done: the rate was not supported |
| result | output | 2 | With done: PLL step result code |

## Verification
The embedded assertions check the following on every cycle:
- The write port and the PLL request are never active together.
- A stalled write holds its values, and a PLL request holds its target until acknowledged.
- Addresses start at the base and advance by one step per handshake.
- done is a single-cycle pulse.
- An unsupported rate ends the sequence at once with the rejection flag.

Only the bench scenarios can show the following:
- The PLL-first versus dividers-first ordering against the sampled current rate, including the equal case.
- The full divisor table for every supported rate.
- The PLL target mapping.
- That the result code is carried through.
- That a request raised while busy leaves no trace.

// File: rtl/bus_rate_seq_pkg.sv
package bus_rate_seq_pkg;

    localparam int MHZ_W     = 12;
    localparam int NUM_RATES = 4;
    localparam int IDX_W     = $clog2(NUM_RATES);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PLL_PRE,
        ST_DIV_WR,
        ST_PLL_POST,
        ST_FINISH
    } seq_state_t;

    // Supported bus rate for a table index: 200 MHz steps.
    function automatic logic [MHZ_W-1:0] rate_of(input int idx);
        return MHZ_W'(200 * (idx + 1));
    endfunction

    // PLL rate that goes with a table index.
    function automatic logic [MHZ_W-1:0] pll_of(input int idx);
        return (idx == 2) ? MHZ_W'(600) : MHZ_W'(800);
    endfunction

    // Divisor for divider slot 'slot' at rate index 'idx'.
    // Packed row holds index 0 in the top byte.
    function automatic logic [7:0] div_for(input int slot, input logic [IDX_W-1:0] idx);
        logic [31:0] row;
        case (slot)
            0, 8, 10, 13: row = {8'd4,  8'd4,  8'd3,  8'd4};
            1:            row = {8'd4,  8'd2,  8'd1,  8'd1};
            6:            row = {8'd1,  8'd1,  8'd1,  8'd1};
            11:           row = {8'd8,  8'd8,  8'd6,  8'd8};
            12, 14:       row = {8'd24, 8'd24, 8'd18, 8'd24};
            15:           row = {8'd16, 8'd16, 8'd12, 8'd16};
            default:      row = {8'd2,  8'd2,  8'd2,  8'd2};
        endcase
        return row[8*(3 - int'(idx)) +: 8];
    endfunction

endpackage

// File: rtl/brs_rate_lookup.sv
module brs_rate_lookup
    import bus_rate_seq_pkg::*;
(
    input  logic [MHZ_W-1:0] rate_mhz,
    output logic             hit,
    output logic [IDX_W-1:0] idx,
    output logic [MHZ_W-1:0] pll_mhz
);

    always_comb begin
        hit     = 1'b0;
        idx     = '0;
        pll_mhz = '0;
        for (int i = 0; i < NUM_RATES; i++) begin
            if (!hit && rate_mhz == rate_of(i)) begin
                hit     = 1'b1;
                idx     = IDX_W'(i);
                pll_mhz = pll_of(i);
            end
        end
    end

endmodule

// File: rtl/brs_div_writer.sv
module brs_div_writer
    import bus_rate_seq_pkg::*;
#(
    parameter int NUM_DIV   = 16,
    parameter int ADDR_W    = 12,
    parameter int DIV_W     = 8,
    parameter int BASE_ADDR = 'h180,
    parameter int ADDR_STEP = 'h10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [IDX_W-1:0]  idx,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DIV_W-1:0]  wr_data,
    output logic              finished
);

    localparam int CNT_W = $clog2(NUM_DIV);

    logic             active_q;
    logic [CNT_W-1:0] cnt_q;
    logic [IDX_W-1:0] idx_q;
    logic             last;
    logic             fire;

    assign last     = (cnt_q == CNT_W'(NUM_DIV - 1));
    assign fire     = active_q && wr_ready;
    assign finished = fire && last;
    assign wr_valid = active_q;
    assign wr_addr  = ADDR_W'(BASE_ADDR + int'(cnt_q) * ADDR_STEP);
    assign wr_data  = DIV_W'(div_for(int'(cnt_q), idx_q));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
            idx_q    <= '0;
        end else if (start) begin
            active_q <= 1'b1;
            cnt_q    <= '0;
            idx_q    <= idx;
        end else if (fire) begin
            cnt_q <= cnt_q + 1'b1;
            if (last) active_q <= 1'b0;
        end
    end

    // R7: a stalled write holds its contents
    a_r7_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

    // R5: a burst opens at the base address
    a_r5_first_addr: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_valid) |-> (wr_addr == ADDR_W'(BASE_ADDR)));

    // R5: each accepted write moves one step up
    a_r5_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready && wr_addr != ADDR_W'(BASE_ADDR + (NUM_DIV - 1) * ADDR_STEP))
        |=> (wr_valid && wr_addr == $past(wr_addr) + ADDR_W'(ADDR_STEP)));

endmodule

// File: rtl/bus_rate_seq.sv
module bus_rate_seq
    import bus_rate_seq_pkg::*;
#(
    parameter int NUM_DIV   = 16,
    parameter int ADDR_W    = 12,
    parameter int DIV_W     = 8,
    parameter int RES_W     = 2,
    parameter int BASE_ADDR = 'h180,
    parameter int ADDR_STEP = 'h10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [MHZ_W-1:0]  req_rate_mhz,
    input  logic [MHZ_W-1:0]  cur_pll_mhz,
    output logic              pll_req,
    output logic [MHZ_W-1:0]  pll_target_mhz,
    input  logic              pll_ack,
    input  logic [RES_W-1:0]  pll_result,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DIV_W-1:0]  wr_data,
    output logic              done,
    output logic              rejected,
    output logic [RES_W-1:0]  result
);

    seq_state_t       state_q, state_d;
    logic             hit;
    logic [IDX_W-1:0] lk_idx;
    logic [MHZ_W-1:0] lk_pll;
    logic             accept;
    logic             pll_lower;
    logic             wr_start;
    logic             wr_finished;
    logic             pll_first_q;
    logic             rej_q;
    logic [RES_W-1:0] res_q;
    logic [MHZ_W-1:0] tgt_q;
    logic [IDX_W-1:0] idx_q;

    brs_rate_lookup u_lookup (
        .rate_mhz (req_rate_mhz),
        .hit      (hit),
        .idx      (lk_idx),
        .pll_mhz  (lk_pll)
    );

    assign accept    = req_valid && (state_q == ST_IDLE);
    assign pll_lower = lk_pll < cur_pll_mhz;
    assign wr_start  = (accept && hit && !pll_lower)
                    || (state_q == ST_PLL_PRE && pll_ack);

    brs_div_writer #(
        .NUM_DIV   (NUM_DIV),
        .ADDR_W    (ADDR_W),
        .DIV_W     (DIV_W),
        .BASE_ADDR (BASE_ADDR),
        .ADDR_STEP (ADDR_STEP)
    ) u_writer (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (wr_start),
        .idx      ((state_q == ST_IDLE) ? lk_idx : idx_q),
        .wr_valid (wr_valid),
        .wr_ready (wr_ready),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .finished (wr_finished)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (!hit)           state_d = ST_FINISH;
                    else if (pll_lower) state_d = ST_PLL_PRE;
                    else                state_d = ST_DIV_WR;
                end
            end
            ST_PLL_PRE:  if (pll_ack) state_d = ST_DIV_WR;
            ST_DIV_WR:   if (wr_finished) state_d = pll_first_q ? ST_FINISH : ST_PLL_POST;
            ST_PLL_POST: if (pll_ack) state_d = ST_FINISH;
            ST_FINISH:   state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // Per-request context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pll_first_q <= 1'b0;
            rej_q       <= 1'b0;
            res_q       <= '0;
            tgt_q       <= '0;
            idx_q       <= '0;
        end else begin
            if (accept) begin
                pll_first_q <= pll_lower;
                rej_q       <= !hit;
                res_q       <= '0;
                tgt_q       <= lk_pll;
                idx_q       <= lk_idx;
            end
            if ((state_q == ST_PLL_PRE || state_q == ST_PLL_POST) && pll_ack)
                res_q <= pll_result;
        end
    end

    // Output decode
    always_comb begin
        req_ready = 1'b0;
        pll_req   = 1'b0;
        done      = 1'b0;
        unique case (state_q)
            ST_IDLE:     req_ready = 1'b1;
            ST_PLL_PRE:  pll_req   = 1'b1;
            ST_DIV_WR:   ;
            ST_PLL_POST: pll_req   = 1'b1;
            ST_FINISH:   done      = 1'b1;
            default:     ;
        endcase
    end

    assign pll_target_mhz = tgt_q;
    assign rejected       = done && rej_q;
    assign result         = done ? res_q : '0;

    // R1: unsupported rate ends at once with the rejection flag
    a_r1_reject_now: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !hit) |=> (done && rejected && !wr_valid && !pll_req));

    // R3 / R4: write port and PLL request never overlap
    a_r4_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        pll_req |-> !wr_valid);

    // R8: PLL request held with stable target until acknowledged
    a_r8_pll_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (pll_req && !pll_ack) |=> (pll_req && $stable(pll_target_mhz)));

    // R9: done is a single-cycle pulse
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: not ready while busy
    a_r9_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid || pll_req || done) |-> !req_ready);

endmodule

// File: tb/bus_rate_seq_tb_top.sv
module bus_rate_seq_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [11:0] req_rate_mhz = '0;
    logic [11:0] cur_pll_mhz = '0;
    logic        pll_req;
    logic [11:0] pll_target_mhz;
    logic        pll_ack = 1'b0;
    logic [1:0]  pll_result = '0;
    logic        wr_valid;
    logic        wr_ready = 1'b0;
    logic [11:0] wr_addr;
    logic [7:0]  wr_data;
    logic        done;
    logic        rejected;
    logic [1:0]  result;

    int checks = 0;
    int fails  = 0;

    // monitor records
    logic [11:0] waddr [0:31];
    logic [7:0]  wdata [0:31];
    int          wcount = 0;
    int          wr_before_pll = -1;
    int          pll_acks = 0;
    logic [11:0] seen_tgt = '0;
    int          cyc = 0;
    int          pll_wait = 0;
    logic        ack_given = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_rate_seq dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_rate_mhz(req_rate_mhz), .cur_pll_mhz(cur_pll_mhz),
        .pll_req(pll_req), .pll_target_mhz(pll_target_mhz),
        .pll_ack(pll_ack), .pll_result(pll_result),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
        .done(done), .rejected(rejected), .result(result)
    );

    task automatic check(input string req, input logic ok, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_div(input int k, input int idx);
        int base;
        if (k == 1) return (idx == 0) ? 4 : (idx == 1) ? 2 : 1;
        if (k == 0 || k == 8 || k == 10 || k == 13) base = 4;
        else if (k == 11) base = 8;
        else if (k == 12 || k == 14) base = 24;
        else if (k == 15) base = 16;
        else if (k == 6) base = 1;
        else base = 2;
        if (base >= 3 && idx == 2) return base * 3 / 4;
        return base;
    endfunction

    // write-port sink and PLL responder; samples then drives at the falling edge
    always @(negedge clk) begin
        cyc++;
        wr_ready = (cyc % 3) != 1;
        if (wr_valid && wr_ready && rst_n) begin
            if (wcount < 32) begin
                waddr[wcount] = wr_addr;
                wdata[wcount] = wr_data;
            end
            wcount++;
        end
        pll_ack = 1'b0;
        if (pll_req && !ack_given) begin
            if (pll_wait == 2) begin
                pll_ack       = 1'b1;
                ack_given     = 1'b1;
                wr_before_pll = wcount;
                seen_tgt      = pll_target_mhz;
                pll_acks++;
                pll_wait      = 0;
            end else begin
                pll_wait++;
            end
        end
        if (!pll_req) ack_given = 1'b0;
    end

    task automatic clear_rec();
        wcount = 0;
        wr_before_pll = -1;
        pll_acks = 0;
        seen_tgt = '0;
    endtask

    task automatic run_txn(input int rate, input int cur, input logic inject, input logic [1:0] code);
        int idx;
        int exp_pll;
        int waited;
        logic rej_s;
        logic [1:0] res_s;
        idx = -1;
        for (int i = 0; i < 4; i++) if (rate == 200 * (i + 1)) idx = i;
        exp_pll = (idx == 2) ? 600 : 800;
        @(negedge clk);
        clear_rec();
        pll_result   = code;
        req_rate_mhz = 12'(rate);
        cur_pll_mhz  = 12'(cur);
        req_valid    = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        waited = 1;
        while (!done) begin
            if (inject && waited == 4) begin
                req_valid    = 1'b1;
                req_rate_mhz = 12'd400;
            end else begin
                req_valid = 1'b0;
            end
            @(negedge clk);
            waited++;
        end
        req_valid = 1'b0;
        rej_s = rejected;
        res_s = result;
        if (idx < 0) begin
            check("R1 reject flag", rej_s == 1'b1, rej_s, 1);
            check("R1 reject latency", waited == 1, waited, 1);
            check("R1 no writes", wcount == 0, wcount, 0);
            check("R1 no pll", pll_acks == 0, pll_acks, 0);
        end else begin
            check("R1 accepted", rej_s == 1'b0, rej_s, 0);
            check("R5 write count", wcount == 16, wcount, 16);
            check("R8 one pll step", pll_acks == 1, pll_acks, 1);
            check("R2 pll target", seen_tgt == 12'(exp_pll), seen_tgt, exp_pll);
            if (exp_pll < cur)
                check("R3 pll before dividers", wr_before_pll == 0, wr_before_pll, 0);
            else
                check("R4 dividers before pll", wr_before_pll == 16, wr_before_pll, 16);
            check("R8 result code", res_s == code, res_s, code);
            for (int k = 0; k < 16 && k < wcount; k++) begin
                check("R5 address", waddr[k] == 12'('h180 + 'h10 * k), waddr[k], 'h180 + 'h10 * k);
                check("R6 divisor", wdata[k] == 8'(exp_div(k, idx)), wdata[k], exp_div(k, idx));
            end
        end
        @(negedge clk);
        check("R9 done one cycle", done == 1'b0, done, 0);
        check("R9 ready again", req_ready == 1'b1, req_ready, 1);
        if (inject) begin
            clear_rec();
            waited = 0;
            for (int c = 0; c < 40; c++) begin
                @(negedge clk);
                if (done) waited++;
            end
            check("R9 busy request ignored (done)", waited == 0, waited, 0);
            check("R9 busy request ignored (writes)", wcount == 0, wcount, 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 reset ready", req_ready == 1'b1, req_ready, 1);
        check("R10 reset done", done == 1'b0, done, 0);
        check("R10 reset wr_valid", wr_valid == 1'b0, wr_valid, 0);
        check("R10 reset pll_req", pll_req == 1'b0, pll_req, 0);

        for (int r = 1; r <= 4; r++) begin
            for (int c = 0; c < 5; c++) begin
                int curs [5] = '{500, 600, 700, 800, 1000};
                run_txn(200 * r, curs[c], 1'b0, 2'((r + c) % 4));
            end
        end
        begin
            int bad [6] = '{0, 199, 201, 300, 1000, 4095};
            foreach (bad[b]) run_txn(bad[b], 800, 1'b0, 2'd0);
        end
        run_txn(600, 800, 1'b1, 2'd3);
        run_txn(800, 600, 1'b1, 2'd1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=0", WATCHDOG);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule